// File: doc/BRIEF.md
# Dual-Mode Block RAM

This block is a synthesizable on-chip memory model that works in one of two modes, chosen by a parameter. In true dual-port mode, ports A and B are independent and equal. Each port reads and writes a slice of 9, 18 or 36 bits, and each 9-bit lane is one data byte plus its parity bit. In simple dual-port mode, the same pins are re-used. Port A's enable and address become the read controls, and port B's become the write controls. The data path widens to a 72-bit word: port A's data pins carry the low half and port B's carry the high half, on both the write and the read side.

Storage is an array of 72-bit rows. Each row holds eight 9-bit lanes. Parity is stored like any other data bit; the block never computes it. Each read side has a read latch, which is updated on an enabled clock edge. The latch can be followed by an optional output register with its own clock enable. Each read side can be forced to a programmable reset value:
- The latch reset applies when the output register is absent.
- The register reset applies when the output register is present. A parameter chooses whether it overrides the register clock enable or needs that enable.

Both ports share one clock.

Top module: `dual_mode_bram`

## Requirements
- R1: In dual-port mode with a port width of 36, 18 or 9, the lowest 1, 2 or 3 address bits select a slice inside a row, and the bits above them select the row. Port lane j is data bits [8j+7:8j] with parity bit j. Lanes beyond the port width read as zero.
- R2: Write enable bit j writes lane j, byte and parity together. Lanes whose enable is low keep their contents. In dual-port mode, port B's enable bits 7..4 are ignored.
- R3: Reads are read-first: a read of an address written on the same edge returns the old contents, and the new contents appear on the next read.
- R4: Either port can read data that the other port wrote.
- R5: The read latch changes only on an edge where its enable is high.
- R6: Without the output register, a latch reset with the enable high loads the reset value, given as {parity[3:0], data[31:0]}. In this mode the register reset has no effect.
- R7: With the output register, read data reaches the output one edge after the latch, and only on an edge where the register clock enable is high.
- R8: With the register-reset-first setting, a register reset loads the reset value whatever the clock enable. With the other setting, the reset acts only together with the clock enable, and otherwise the output holds.
- R9: In simple dual-port mode, port B's enable and address write the 72-bit row. Write lanes 0-3 come from port A's data pins and lanes 4-7 from port B's. The write enable is 8 bits, one per lane, and port A's write enable is ignored.
- R10: In simple dual-port mode, port A's enable and address read the row. The low half appears on port A's outputs and the high half on port B's outputs. Port A's latch reset, register reset and register enable act on both halves, which reset to port A's and port B's reset values respectively.
- R11: When both ports write the same lane of the same row on one edge, that lane is undefined, and the other lanes written on that edge hold their written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| en_a | input | 1 | Port A enable (read enable in simple dual-port mode) |
| we_a | input | 4 | Port A per-lane write enable (ignored in simple dual-port mode) |
| addr_a | input | 16 | Port A address (read address in simple dual-port mode) |
| din_a | input | 32 | Port A write data (low write half in simple dual-port mode) |
| dinp_a | input | 4 | Port A write parity |
| ce_a | input | 1 | Port A output register clock enable |
| rst_reg_a | input | 1 | Port A output register synchronous reset |
| rst_lat_a | input | 1 | Port A read latch synchronous reset |
| dout_a | output | 32 | Port A read data (low half in simple dual-port mode) |
| doutp_a | output | 4 | Port A read parity |
| en_b | input | 1 | Port B enable (write enable in simple dual-port mode) |
| we_b | input | 8 | Port B per-lane write enable |
| addr_b | input | 16 | Port B address (write address in simple dual-port mode) |
| din_b | input | 32 | Port B write data (high write half in simple dual-port mode) |
| dinp_b | input | 4 | Port B write parity |
| ce_b | input | 1 | Port B output register clock enable |
| rst_reg_b | input | 1 | Port B output register synchronous reset |
| rst_lat_b | input | 1 | Port B read latch synchronous reset |
| dout_b | output | 32 | Port B read data (high half in simple dual-port mode) |
| doutp_b | output | 4 | Port B read parity |

## Verification
A write and a read of the same row can land on the same edge. The bench provokes this by having port B write an address on the very edge on which port A reads it. It then expects the old word from that read and the new word from the following read. Two writes can also meet in one lane. The bench drives both ports at one row with overlapping lane enables and reports the clash. It leaves the clashing lane out of the compare and checks the lanes that only one port wrote.

// File: rtl/dual_mode_bram.sv
module dual_mode_bram #(
  parameter bit          SDP_MODE    = 1'b0,
  parameter int          PORT_W      = 36,
  parameter int          ROW_BITS    = 6,
  parameter bit          OUT_REG_A   = 1'b0,
  parameter bit          OUT_REG_B   = 1'b0,
  parameter bit          RST_FIRST_A = 1'b1,
  parameter bit          RST_FIRST_B = 1'b1,
  parameter logic [35:0] RST_VAL_A   = '0,
  parameter logic [35:0] RST_VAL_B   = '0
) (
  input  logic        clk,
  input  logic        en_a,
  input  logic [3:0]  we_a,
  input  logic [15:0] addr_a,
  input  logic [31:0] din_a,
  input  logic [3:0]  dinp_a,
  input  logic        ce_a,
  input  logic        rst_reg_a,
  input  logic        rst_lat_a,
  output logic [31:0] dout_a,
  output logic [3:0]  doutp_a,
  input  logic        en_b,
  input  logic [7:0]  we_b,
  input  logic [15:0] addr_b,
  input  logic [31:0] din_b,
  input  logic [3:0]  dinp_b,
  input  logic        ce_b,
  input  logic        rst_reg_b,
  input  logic        rst_lat_b,
  output logic [31:0] dout_b,
  output logic [3:0]  doutp_b
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int LANES = SDP_MODE ? 4 : PORT_W / 9;
  localparam int SEL_W = (PORT_W == 36) ? 1 : (PORT_W == 18) ? 2 : 3;
  localparam int RSH   = SDP_MODE ? 0 : SEL_W;
  localparam bit REG_B = SDP_MODE ? OUT_REG_A : OUT_REG_B;
  localparam bit PRI_B = SDP_MODE ? RST_FIRST_A : RST_FIRST_B;

  logic [8:0] mem [ROWS][8];
  logic [3:0][8:0] lat_a, lat_b, q_a, q_b, pin_a, pin_b, rv_a, rv_b, o_a, o_b;
  logic [7:0][8:0] wr_b;

  wire [ROW_BITS-1:0] row_a = addr_a[RSH +: ROW_BITS];
  wire [ROW_BITS-1:0] row_b = addr_b[RSH +: ROW_BITS];
  wire [2:0] base_a = SDP_MODE ? 3'd0 : 3'(addr_a[SEL_W-1:0] * LANES);
  wire [2:0] base_b = SDP_MODE ? 3'd4 : 3'(addr_b[SEL_W-1:0] * LANES);
  wire unused_hi = &{1'b0, addr_a, addr_b};

  wire                rd_en_b = SDP_MODE ? en_a      : en_b;
  wire                rstl_b  = SDP_MODE ? rst_lat_a : rst_lat_b;
  wire                rstr_b  = SDP_MODE ? rst_reg_a : rst_reg_b;
  wire                cex_b   = SDP_MODE ? ce_a      : ce_b;
  wire [ROW_BITS-1:0] rrow_b  = SDP_MODE ? row_a     : row_b;

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      pin_a[j] = {dinp_a[j], din_a[8*j +: 8]};
      pin_b[j] = {dinp_b[j], din_b[8*j +: 8]};
      rv_a[j]  = {RST_VAL_A[32+j], RST_VAL_A[8*j +: 8]};
      rv_b[j]  = {RST_VAL_B[32+j], RST_VAL_B[8*j +: 8]};
    end
  end

  assign wr_b = SDP_MODE ? {pin_b, pin_a} : {pin_b, pin_b};

  function automatic logic [3:0][8:0] fetch(input logic [ROW_BITS-1:0] r, input logic [2:0] b);
    logic [3:0][8:0] f;
    for (int j = 0; j < 4; j++)
      f[j] = (j < LANES) ? mem[r][3'(b + 3'(j))] : 9'd0;
    return f;
  endfunction

  always_ff @(posedge clk) begin
    if (!SDP_MODE && en_a)
      for (int j = 0; j < LANES; j++)
        if (we_a[j]) mem[row_a][3'(base_a + 3'(j))] <= pin_a[j];
    if (en_b)
      for (int k = 0; k < 8; k++) begin
        if (SDP_MODE) begin
          if (we_b[k]) mem[row_b][3'(k)] <= wr_b[k];
        end else if (k < LANES && we_b[k]) begin
          mem[row_b][3'(base_b + 3'(k))] <= wr_b[k];
        end
      end
  end

  always_ff @(posedge clk) begin
    if (en_a)    lat_a <= (rst_lat_a && !OUT_REG_A) ? rv_a : fetch(row_a, base_a);
    if (rd_en_b) lat_b <= (rstl_b && !REG_B) ? rv_b : fetch(rrow_b, base_b);

    if (RST_FIRST_A ? rst_reg_a : (rst_reg_a && ce_a)) q_a <= rv_a;
    else if (ce_a)                                     q_a <= lat_a;

    if (PRI_B ? rstr_b : (rstr_b && cex_b)) q_b <= rv_b;
    else if (cex_b)                         q_b <= lat_b;
  end

  assign o_a = OUT_REG_A ? q_a : lat_a;
  assign o_b = REG_B ? q_b : lat_b;

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      dout_a[8*j +: 8] = o_a[j][7:0];
      doutp_a[j]       = o_a[j][8];
      dout_b[8*j +: 8] = o_b[j][7:0];
      doutp_b[j]       = o_b[j][8];
    end
  end
endmodule

// File: rtl/dual_mode_bram_chk.sv
module dual_mode_bram_chk #(
  parameter bit          SDP_MODE    = 1'b0,
  parameter bit          OUT_REG_A   = 1'b0,
  parameter bit          OUT_REG_B   = 1'b0,
  parameter bit          RST_FIRST_A = 1'b1,
  parameter bit          RST_FIRST_B = 1'b1,
  parameter logic [35:0] RST_VAL_A   = '0,
  parameter logic [35:0] RST_VAL_B   = '0
) (
  input logic        clk,
  input logic        en_a,
  input logic        ce_a,
  input logic        rst_reg_a,
  input logic        rst_lat_a,
  input logic        ce_b,
  input logic        rst_reg_b,
  input logic [31:0] dout_a,
  input logic [3:0]  doutp_a,
  input logic [31:0] dout_b,
  input logic [3:0]  doutp_b
);
  bit armed;
  always_ff @(posedge clk) armed <= 1'b1;

  wire [35:0] oa = {doutp_a, dout_a};
  wire [35:0] ob = {doutp_b, dout_b};

  AST_LAT_RESET_A: assert property (@(posedge clk) disable iff (!armed)
    (!OUT_REG_A && en_a && rst_lat_a) |=> (oa == RST_VAL_A));                             // R6
  AST_LAT_HOLD_A: assert property (@(posedge clk) disable iff (!armed)
    (!OUT_REG_A && !en_a) |=> $stable(oa));                                               // R5
  AST_REG_RESET_A: assert property (@(posedge clk) disable iff (!armed)
    (OUT_REG_A && rst_reg_a && (RST_FIRST_A || ce_a)) |=> (oa == RST_VAL_A));             // R8
  AST_REG_HOLD_A: assert property (@(posedge clk) disable iff (!armed)
    (OUT_REG_A && !ce_a && !(RST_FIRST_A && rst_reg_a)) |=> $stable(oa));                 // R7
  AST_REG_RESET_B: assert property (@(posedge clk) disable iff (!armed)
    (!SDP_MODE && OUT_REG_B && rst_reg_b && (RST_FIRST_B || ce_b)) |=> (ob == RST_VAL_B)); // R8
  AST_SDP_HIGH_RESET: assert property (@(posedge clk) disable iff (!armed)
    (SDP_MODE && OUT_REG_A && rst_reg_a && (RST_FIRST_A || ce_a)) |=> (ob == RST_VAL_B));  // R10
endmodule

bind dual_mode_bram dual_mode_bram_chk #(
  .SDP_MODE(SDP_MODE), .OUT_REG_A(OUT_REG_A), .OUT_REG_B(OUT_REG_B),
  .RST_FIRST_A(RST_FIRST_A), .RST_FIRST_B(RST_FIRST_B),
  .RST_VAL_A(RST_VAL_A), .RST_VAL_B(RST_VAL_B)
) u_chk (
  .clk(clk), .en_a(en_a), .ce_a(ce_a), .rst_reg_a(rst_reg_a), .rst_lat_a(rst_lat_a),
  .ce_b(ce_b), .rst_reg_b(rst_reg_b),
  .dout_a(dout_a), .doutp_a(doutp_a), .dout_b(dout_b), .doutp_b(doutp_b)
);

// File: tb/tb_dual_mode_bram.sv
module tb_dual_mode_bram;
  localparam logic [35:0] RV0A = 36'h9_DEAD_BEEF;
  localparam logic [35:0] RV0B = 36'h5_1234_5678;
  localparam logic [35:0] RVSA = 36'hA_0BAD_F00D;
  localparam logic [35:0] RVSB = 36'h3_CAFE_0001;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        en_a, ce_a, rst_reg_a, rst_lat_a, en_b, ce_b, rst_reg_b, rst_lat_b;
  logic [3:0]  we_a, dinp_a, dinp_b;
  logic [7:0]  we_b;
  logic [15:0] addr_a, addr_b;
  logic [31:0] din_a, din_b;
  logic [31:0] oa0, ob0, oa9, ob9, oas, obs;
  logic [3:0]  pa0, pb0, pa9, pb9, pas, pbs;
  int n_tests = 0;
  int n_fail  = 0;

  dual_mode_bram #(.OUT_REG_B(1'b1), .RST_FIRST_B(1'b0), .RST_VAL_A(RV0A), .RST_VAL_B(RV0B)) dut (
    .clk(clk), .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a), .dinp_a(dinp_a),
    .ce_a(ce_a), .rst_reg_a(rst_reg_a), .rst_lat_a(rst_lat_a), .dout_a(oa0), .doutp_a(pa0),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b), .dinp_b(dinp_b),
    .ce_b(ce_b), .rst_reg_b(rst_reg_b), .rst_lat_b(rst_lat_b), .dout_b(ob0), .doutp_b(pb0));

  dual_mode_bram #(.PORT_W(9)) dut_w9 (
    .clk(clk), .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a), .dinp_a(dinp_a),
    .ce_a(ce_a), .rst_reg_a(rst_reg_a), .rst_lat_a(rst_lat_a), .dout_a(oa9), .doutp_a(pa9),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b), .dinp_b(dinp_b),
    .ce_b(ce_b), .rst_reg_b(rst_reg_b), .rst_lat_b(rst_lat_b), .dout_b(ob9), .doutp_b(pb9));

  dual_mode_bram #(.SDP_MODE(1'b1), .OUT_REG_A(1'b1), .RST_FIRST_A(1'b1),
                   .RST_VAL_A(RVSA), .RST_VAL_B(RVSB)) dut_sdp (
    .clk(clk), .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a), .dinp_a(dinp_a),
    .ce_a(ce_a), .rst_reg_a(rst_reg_a), .rst_lat_a(rst_lat_a), .dout_a(oas), .doutp_a(pas),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b), .dinp_b(dinp_b),
    .ce_b(ce_b), .rst_reg_b(rst_reg_b), .rst_lat_b(rst_lat_b), .dout_b(obs), .doutp_b(pbs));

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    en_a = 0; we_a = 0; addr_a = 0; din_a = 0; dinp_a = 0; ce_a = 0; rst_reg_a = 0; rst_lat_a = 0;
    en_b = 0; we_b = 0; addr_b = 0; din_b = 0; dinp_b = 0; ce_b = 0; rst_reg_b = 0; rst_lat_b = 0;
  endtask

  task automatic chk(input string req, input logic [35:0] got, input logic [35:0] exp,
                     input logic [35:0] mask = '1);
    n_tests++;
    if (((got ^ exp) & mask) != 36'd0) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (mask %h)", req, got, exp, mask);
    end
  endtask

  task automatic t_reset();
    idle(); en_a = 1; rst_lat_a = 1; rst_reg_b = 1; ce_b = 1; cyc(); idle();
    chk("R6 latch reset value A", {pa0, oa0}, RV0A);
    chk("R8 register reset with enable B", {pb0, ob0}, RV0B);
    chk("R6 latch reset default zero", {pa9, oa9}, 36'd0);
  endtask

  task automatic t_write_read();
    idle(); en_a = 1; we_a = 4'hF; addr_a = 5; din_a = 32'h1122_3344; dinp_a = 4'hA; cyc();
    we_a = 0; cyc();
    chk("R1 full-width write and read", {pa0, oa0}, {4'hA, 32'h1122_3344});
    we_a = 4'b0101; din_a = 32'hAABB_CCDD; dinp_a = 4'hF; cyc();
    we_a = 0; cyc();
    chk("R2 lane-masked write", {pa0, oa0}, {4'hF, 32'h11BB_33DD});
    idle(); en_b = 1; we_b = 8'hF0; addr_b = 5; din_b = 32'h0; dinp_b = 0; cyc();
    idle(); en_a = 1; addr_a = 5; cyc();
    chk("R2 upper B enables ignored", {pa0, oa0}, {4'hF, 32'h11BB_33DD});
  endtask

  task automatic t_read_first();
    idle(); en_a = 1; addr_a = 5;
    en_b = 1; we_b = 8'h0F; addr_b = 5; din_b = 32'h5566_7788; dinp_b = 4'h3; cyc();
    chk("R3 read-first old data", {pa0, oa0}, {4'hF, 32'h11BB_33DD});
    en_b = 0; we_b = 0; cyc();
    chk("R3 R4 new data next read", {pa0, oa0}, {4'h3, 32'h5566_7788});
  endtask

  task automatic t_out_reg();
    idle(); en_b = 1; addr_b = 5; cyc();
    chk("R7 register waits for clock enable", {pb0, ob0}, RV0B);
    en_b = 0; ce_b = 1; addr_b = 4; cyc();
    chk("R7 R5 data one edge after latch", {pb0, ob0}, {4'h3, 32'h5566_7788});
    ce_b = 0; en_b = 1; addr_b = 4; cyc();
    en_b = 0; cyc();
    chk("R7 register holds with enable low", {pb0, ob0}, {4'h3, 32'h5566_7788});
  endtask

  task automatic t_rst_pri();
    idle(); rst_reg_b = 1; cyc();
    chk("R8 gated reset ignored without enable", {pb0, ob0}, {4'h3, 32'h5566_7788});
    ce_b = 1; cyc(); idle();
    chk("R8 gated reset with enable", {pb0, ob0}, RV0B);
  endtask

  task automatic t_latch_hold();
    idle(); en_a = 1; we_a = 4'hF; addr_a = 4; din_a = 32'hCAFE_D00D; dinp_a = 4'h6; cyc();
    we_a = 0; addr_a = 5; cyc();
    chk("R1 slice of same row untouched", {pa0, oa0}, {4'h3, 32'h5566_7788});
    en_a = 0; addr_a = 4; rst_lat_a = 1; cyc();
    chk("R5 latch holds when disabled", {pa0, oa0}, {4'h3, 32'h5566_7788});
    en_a = 1; rst_lat_a = 0; rst_reg_a = 1; cyc(); idle();
    chk("R6 register reset no effect", {pa0, oa0}, {4'h6, 32'hCAFE_D00D});
  endtask

  task automatic t_width9();
    for (int k = 8; k < 12; k++) begin
      idle(); en_a = 1; we_a = 4'hF; addr_a = 16'(k);
      din_a = {24'hFFFFFF, 8'(8'h10 + k)}; dinp_a = {3'b111, k[0]}; cyc();
    end
    for (int k = 8; k < 12; k++) begin
      idle(); en_b = 1; addr_b = 16'(k); cyc();
      chk("R1 R4 9-bit slice read by other port", {pb9, ob9},
          {3'b000, k[0], 24'd0, 8'(8'h10 + k)});
    end
  endtask

  task automatic t_sdp();
    idle(); ce_a = 1;
    en_b = 1; we_b = 8'hFF; addr_b = 3;
    din_a = 32'h0102_0304; dinp_a = 4'h9; din_b = 32'hA1A2_A3A4; dinp_b = 4'h6; cyc();
    en_b = 0; we_b = 0; en_a = 1; we_a = 4'hF; addr_a = 3; din_a = 32'hFFFF_FFFF; dinp_a = 4'hF; cyc();
    en_a = 0; we_a = 0; cyc();
    chk("R9 R10 wide word low half", {pas, oas}, {4'h9, 32'h0102_0304});
    chk("R9 R10 wide word high half", {pbs, obs}, {4'h6, 32'hA1A2_A3A4});
    en_a = 1; cyc(); en_a = 0; cyc();
    chk("R9 port A write enable ignored", {pas, oas}, {4'h9, 32'h0102_0304});
    en_b = 1; we_b = 8'h81; addr_b = 3;
    din_a = 32'h0000_00EE; dinp_a = 0; din_b = 32'h7700_0000; dinp_b = 0; cyc();
    en_b = 0; we_b = 0; en_a = 1; cyc(); en_a = 0; cyc();
    chk("R9 eight-lane enable low half", {pas, oas}, {4'h8, 32'h0102_03EE});
    chk("R9 eight-lane enable high half", {pbs, obs}, {4'h6, 32'h77A2_A3A4});
    ce_a = 0; rst_reg_a = 1; cyc(); idle();
    chk("R8 R10 reset-first low half", {pas, oas}, RVSA);
    chk("R8 R10 reset-first high half", {pbs, obs}, RVSB);
  endtask

  task automatic t_conflict();
    idle(); en_a = 1; we_a = 4'hF; addr_a = 7; din_a = 32'h1111_1111; dinp_a = 0; cyc();
    we_a = 4'b0011; din_a = 32'h2222_2222; dinp_a = 4'hF;
    en_b = 1; we_b = 8'h06; addr_b = 7; din_b = 32'h3333_3333; dinp_b = 4'hF; cyc();
    $display("NOTE R11: lane 1 at address 7 written by both ports, value undefined and excluded");
    idle(); en_a = 1; addr_a = 7; cyc(); idle();
    chk("R11 non-clashing lanes after collision", {pa0, oa0}, {4'b0101, 32'h1133_0022},
        {4'b1101, 32'hFFFF_00FF});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle();
    repeat (2) cyc();
    t_reset();
    t_write_read();
    t_read_first();
    t_out_reg();
    t_rst_pri();
    t_latch_hold();
    t_width9();
    t_sdp();
    t_conflict();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule